// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor Core

This block is a small 32-bit processor core that completes every instruction in one clock. Each cycle it fetches the word addressed by its program counter from a private instruction store. It decodes the opcode and function fields in one flat combinational decoder, reads two operands from a 32-entry register bank, and runs them through a five-function arithmetic unit. In the same cycle it either writes a result back, stores a word to its private data store, or redirects the program counter on an equality branch. The supported operations are register add, subtract, bitwise AND, bitwise OR, signed set-less-than, word load, word store, and branch-if-equal.

The two word-wide stores are filled through a load port while reset is held. After reset is released the core runs on its own. The write-back, store and program-counter activity appears on observation outputs, so a surrounding environment can follow execution. There is no state machine: the only sequential state is the program counter, the register bank and the two stores. Reset clears the program counter and the register bank and leaves the stores untouched.

Top module: `sc_core`

## Requirements
- R1: A synchronous active-high reset sets the program counter to 0 and clears all 32 registers to 0. The data store keeps its contents through reset.
- R2: When an instruction is not a taken branch, the program counter advances by 4 on the next rising edge.
- R3: With opcode 000000, func 100000 adds, 100010 subtracts (rs minus rt), 100100 ANDs and 100101 ORs the registers named by bits [25:21] (rs) and [20:16] (rt). The result is written to the register named by bits [15:11] (rd).
- R4: With opcode 000000 and func 101010, rd receives 1 when rs is less than rt as a signed two's-complement number, and 0 otherwise.
- R5: Opcode 100011 loads the data-store word at byte address rs plus the sign-extended bits [15:0] into register rt.
- R6: Opcode 101011 writes register rt to the data-store word at byte address rs plus the sign-extended bits [15:0], and writes no register.
- R7: Opcode 000100 compares rs and rt. When they are equal, the next program counter is PC+4 plus the sign-extended bits [15:0] shifted left by 2. When they differ, it is PC+4. No register or store is written.
- R8: Register 0 always reads as 0, and write-backs addressed to it are discarded.
- R9: Any other opcode, and any opcode-000000 word with another func code, writes neither a register nor the data store, and only advances the program counter by 4.
- R10: Both stores select a word with byte-address bits [7:2] at the default depth of 64 words. Address bits 1:0 and the bits above bit 7 are ignored, so a store to byte address 256 lands in word 0.
- R11: A load-port write stores ld_data at the word picked by ld_addr, into the instruction store when ld_dmem is 0 and into the data store when it is 1. The core then executes the loaded words, including their destination fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_we | input | 1 | Load-port write strobe |
| ld_dmem | input | 1 | Load-port target: 0 instruction store, 1 data store |
| ld_addr | input | 32 | Load-port byte address |
| ld_data | input | 32 | Load-port write word |
| pc_o | output | 32 | Current program counter |
| wb_en_o | output | 1 | Instruction requests a register write-back |
| wb_addr_o | output | 5 | Write-back destination register |
| wb_data_o | output | 32 | Write-back value |
| dm_we_o | output | 1 | Core store to the data store this cycle |
| dm_addr_o | output | 32 | Effective byte address (arithmetic result) |
| dm_wdata_o | output | 32 | Store data (register rt) |

## Verification
The embedded properties assume that the load port is quiet while reset is low, so the data store changes only through core stores. They also assume that the store depths are powers of two, so the word index is an exact bit slice. The stimulus keeps to these assumptions: every load-port write is made with reset held, and the strobe is dropped before reset is released. A second reset in the middle of the run is only asserted between whole cycles, so every property window starts from a cleared program counter.

// File: rtl/sc_pkg.sv
package sc_pkg;

    localparam int XLEN = 32;
    localparam int NREGS = 32;
    localparam int RAW = $clog2(NREGS);

    localparam logic [5:0] OP_RTYPE = 6'b000000;
    localparam logic [5:0] OP_LOAD  = 6'b100011;
    localparam logic [5:0] OP_STORE = 6'b101011;
    localparam logic [5:0] OP_BREQ  = 6'b000100;

    localparam logic [5:0] FN_ADD = 6'b100000;
    localparam logic [5:0] FN_SUB = 6'b100010;
    localparam logic [5:0] FN_AND = 6'b100100;
    localparam logic [5:0] FN_OR  = 6'b100101;
    localparam logic [5:0] FN_SLT = 6'b101010;

    typedef enum logic [2:0] {
        ALU_AND = 3'b000,
        ALU_OR  = 3'b001,
        ALU_ADD = 3'b010,
        ALU_SUB = 3'b110,
        ALU_SLT = 3'b111
    } alu_sel_e;

    typedef struct packed {
        logic     dst_is_rd;
        logic     reg_wr;
        logic     op2_imm;
        alu_sel_e alu_sel;
        logic     mem_wr;
        logic     mem_rd;
        logic     wb_from_mem;
        logic     is_branch;
    } ctrl_t;

    localparam ctrl_t CTRL_NOP = '{
        dst_is_rd:   1'b0,
        reg_wr:      1'b0,
        op2_imm:     1'b0,
        alu_sel:     ALU_ADD,
        mem_wr:      1'b0,
        mem_rd:      1'b0,
        wb_from_mem: 1'b0,
        is_branch:   1'b0
    };

endpackage

// File: rtl/sc_decoder.sv
module sc_decoder
    import sc_pkg::*;
(
    input  logic [5:0] op,
    input  logic [5:0] fn,
    output ctrl_t      ctrl
);

    logic     r_ok;
    alu_sel_e r_sel;

    // Function-field decode for register-register operations.
    always_comb begin
        r_ok  = 1'b1;
        r_sel = ALU_ADD;
        case (fn)
            FN_ADD:  r_sel = ALU_ADD;
            FN_SUB:  r_sel = ALU_SUB;
            FN_AND:  r_sel = ALU_AND;
            FN_OR:   r_sel = ALU_OR;
            FN_SLT:  r_sel = ALU_SLT;
            default: r_ok  = 1'b0;
        endcase
    end

    // Flat opcode decode straight to the datapath controls.
    always_comb begin
        ctrl = CTRL_NOP;
        case (op)
            OP_RTYPE: begin
                if (r_ok) begin
                    ctrl.dst_is_rd = 1'b1;
                    ctrl.reg_wr    = 1'b1;
                    ctrl.alu_sel   = r_sel;
                end
            end
            OP_LOAD: begin
                ctrl.reg_wr      = 1'b1;
                ctrl.op2_imm     = 1'b1;
                ctrl.alu_sel     = ALU_ADD;
                ctrl.mem_rd      = 1'b1;
                ctrl.wb_from_mem = 1'b1;
            end
            OP_STORE: begin
                ctrl.op2_imm = 1'b1;
                ctrl.alu_sel = ALU_ADD;
                ctrl.mem_wr  = 1'b1;
            end
            OP_BREQ: begin
                ctrl.alu_sel   = ALU_SUB;
                ctrl.is_branch = 1'b1;
            end
            default: ctrl = CTRL_NOP;
        endcase
    end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_sel_e     sel,
    output logic [W-1:0] y,
    output logic         zero
);

    logic lt_signed;

    assign lt_signed = ($signed(a) < $signed(b));

    always_comb begin
        case (sel)
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_SLT: y = {{(W-1){1'b0}}, lt_signed};
            default: y = '0;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/sc_regbank.sv
module sc_regbank #(
    parameter int N = 32,
    parameter int W = 32,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ra_a,
    input  logic [AW-1:0] ra_b,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd,
    output logic [W-1:0]  rd_a,
    output logic [W-1:0]  rd_b
);

    logic [W-1:0] regs [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) begin
                regs[i] <= '0;
            end
        end else if (we && (wa != '0)) begin
            regs[wa] <= wd;
        end
    end

    assign rd_a = (ra_a == '0) ? '0 : regs[ra_a];
    assign rd_b = (ra_b == '0) ? '0 : regs[ra_b];

    AST_R0_HELD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (we && (wa == '0)) |=> (regs[0] == '0)); // R8

endmodule

// File: rtl/sc_wordmem.sv
module sc_wordmem #(
    parameter int WORDS = 64,
    parameter int W = 32,
    localparam int IW = $clog2(WORDS)
) (
    input  logic         clk,
    input  logic         we,
    input  logic [31:0]  waddr,
    input  logic [W-1:0] wdata,
    input  logic [31:0]  raddr,
    output logic [W-1:0] rdata
);

    logic [W-1:0] cells [WORDS];
    logic [IW-1:0] widx;
    logic [IW-1:0] ridx;
    logic unused_addr_bits;

    assign widx = waddr[IW+1:2];
    assign ridx = raddr[IW+1:2];
    assign unused_addr_bits = ^{waddr[31:IW+2], waddr[1:0], raddr[31:IW+2], raddr[1:0]};

    always_ff @(posedge clk) begin
        if (we) begin
            cells[widx] <= wdata;
        end
    end

    assign rdata = cells[ridx];

endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ld_we,
    input  logic        ld_dmem,
    input  logic [31:0] ld_addr,
    input  logic [31:0] ld_data,
    output logic [31:0] pc_o,
    output logic        wb_en_o,
    output logic [4:0]  wb_addr_o,
    output logic [31:0] wb_data_o,
    output logic        dm_we_o,
    output logic [31:0] dm_addr_o,
    output logic [31:0] dm_wdata_o
);

    logic [XLEN-1:0] pc_q;
    logic [XLEN-1:0] pc_next;
    logic [XLEN-1:0] pc_plus4;
    logic [XLEN-1:0] br_target;
    logic [XLEN-1:0] instr;
    logic [5:0]      f_op;
    logic [5:0]      f_fn;
    logic [RAW-1:0]  f_rs;
    logic [RAW-1:0]  f_rt;
    logic [RAW-1:0]  f_rd;
    logic [XLEN-1:0] simm;
    ctrl_t           ctrl;
    logic [XLEN-1:0] rs_val;
    logic [XLEN-1:0] rt_val;
    logic [XLEN-1:0] op2;
    logic [XLEN-1:0] alu_y;
    logic            alu_zero;
    logic [RAW-1:0]  dst;
    logic [XLEN-1:0] dm_raw;
    logic [XLEN-1:0] dm_rd;
    logic [XLEN-1:0] wb_val;
    logic            take_br;
    logic            core_st;
    logic            dm_we_int;
    logic [31:0]     dm_wa;
    logic [31:0]     dm_wd;
    logic            im_we;
    logic            unused_shamt;

    // Fetch
    sc_wordmem #(.WORDS(IMEM_WORDS), .W(XLEN)) u_imem (
        .clk   (clk),
        .we    (im_we),
        .waddr (ld_addr),
        .wdata (ld_data),
        .raddr (pc_q),
        .rdata (instr)
    );

    assign im_we = ld_we & ~ld_dmem;

    // Field split
    assign f_op = instr[31:26];
    assign f_rs = instr[25:21];
    assign f_rt = instr[20:16];
    assign f_rd = instr[15:11];
    assign f_fn = instr[5:0];
    assign simm = {{(XLEN-16){instr[15]}}, instr[15:0]};
    assign unused_shamt = ^instr[10:6];

    sc_decoder u_dec (
        .op   (f_op),
        .fn   (f_fn),
        .ctrl (ctrl)
    );

    // Operand read and execute
    assign dst = ctrl.dst_is_rd ? f_rd : f_rt;

    sc_regbank #(.N(NREGS), .W(XLEN)) u_rf (
        .clk  (clk),
        .rst  (rst),
        .ra_a (f_rs),
        .ra_b (f_rt),
        .we   (ctrl.reg_wr & ~rst),
        .wa   (dst),
        .wd   (wb_val),
        .rd_a (rs_val),
        .rd_b (rt_val)
    );

    assign op2 = ctrl.op2_imm ? simm : rt_val;

    sc_alu #(.W(XLEN)) u_alu (
        .a    (rs_val),
        .b    (op2),
        .sel  (ctrl.alu_sel),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // Data store: load port has priority over a core store
    assign core_st   = ctrl.mem_wr & ~rst;
    assign dm_we_int = (ld_we & ld_dmem) | core_st;
    assign dm_wa     = (ld_we & ld_dmem) ? ld_addr : alu_y;
    assign dm_wd     = (ld_we & ld_dmem) ? ld_data : rt_val;

    sc_wordmem #(.WORDS(DMEM_WORDS), .W(XLEN)) u_dmem (
        .clk   (clk),
        .we    (dm_we_int),
        .waddr (dm_wa),
        .wdata (dm_wd),
        .raddr (alu_y),
        .rdata (dm_raw)
    );

    assign dm_rd  = ctrl.mem_rd ? dm_raw : '0;
    assign wb_val = ctrl.wb_from_mem ? dm_rd : alu_y;

    // Next program counter
    assign pc_plus4  = pc_q + 32'd4;
    assign br_target = pc_plus4 + (simm << 2);
    assign take_br   = ctrl.is_branch & alu_zero;
    assign pc_next   = take_br ? br_target : pc_plus4;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_next;
        end
    end

    // Observation
    assign pc_o       = pc_q;
    assign wb_en_o    = ctrl.reg_wr;
    assign wb_addr_o  = dst;
    assign wb_data_o  = wb_val;
    assign dm_we_o    = core_st;
    assign dm_addr_o  = alu_y;
    assign dm_wdata_o = rt_val;

    AST_RESET_PC_ZERO: assert property (@(posedge clk)
        rst |=> (pc_q == '0)); // R1

    AST_PC_WORD_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        (pc_q[1:0] == 2'b00)); // R2

    AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        !take_br |=> (pc_q == $past(pc_q) + 32'd4)); // R2

    AST_BRANCH_REDIRECT: assert property (@(posedge clk) disable iff (rst)
        take_br |=> (pc_q == $past(br_target))); // R7

    AST_SLT_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
        (wb_en_o && (f_op == OP_RTYPE) && (f_fn == FN_SLT)) |-> (wb_data_o[31:1] == '0)); // R4

    AST_STORE_NO_WRITEBACK: assert property (@(posedge clk) disable iff (rst)
        dm_we_o |-> !wb_en_o); // R6

    AST_UNKNOWN_QUIET: assert property (@(posedge clk) disable iff (rst)
        ((f_op != OP_RTYPE) && (f_op != OP_LOAD) && (f_op != OP_STORE) && (f_op != OP_BREQ))
        |-> (!wb_en_o && !dm_we_o)); // R9

endmodule

// File: tb/tb_sc_core.sv
module tb_sc_core;

    localparam int MW = 64;

    logic        clk = 1'b0;
    logic        rst;
    logic        ld_we;
    logic        ld_dmem;
    logic [31:0] ld_addr;
    logic [31:0] ld_data;
    logic [31:0] pc_o;
    logic        wb_en_o;
    logic [4:0]  wb_addr_o;
    logic [31:0] wb_data_o;
    logic        dm_we_o;
    logic [31:0] dm_addr_o;
    logic [31:0] dm_wdata_o;

    int checks = 0;
    int errors = 0;

    logic [31:0] m_reg [32];
    logic [31:0] m_dm  [MW];
    logic [31:0] m_im  [MW];
    logic [31:0] m_pc;
    bit          m_prev_br;

    always #5 clk = ~clk;

    sc_core dut (
        .clk        (clk),
        .rst        (rst),
        .ld_we      (ld_we),
        .ld_dmem    (ld_dmem),
        .ld_addr    (ld_addr),
        .ld_data    (ld_data),
        .pc_o       (pc_o),
        .wb_en_o    (wb_en_o),
        .wb_addr_o  (wb_addr_o),
        .wb_data_o  (wb_data_o),
        .dm_we_o    (dm_we_o),
        .dm_addr_o  (dm_addr_o),
        .dm_wdata_o (dm_wdata_o)
    );

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
        logic [4:0] s = rs[4:0];
        logic [4:0] t = rt[4:0];
        logic [4:0] d = rd[4:0];
        return {6'b000000, s, t, d, 5'b00000, fn};
    endfunction

    function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
        logic [4:0]  s = rs[4:0];
        logic [4:0]  t = rt[4:0];
        logic [15:0] k = imm[15:0];
        return {op, s, t, k};
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h (pc model %h)", tag, what, act, exp, m_pc);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 32; i++) m_reg[i] = '0;
        m_pc = '0;
        m_prev_br = 1'b0;
    endtask

    // One instruction of the reference model, compared against the ports.
    task automatic step_and_compare();
        logic [31:0] ins, a, b, imm, y, wbd, nxt;
        logic [5:0]  op, fn;
        int          rs, rt, rd, dst, kind;
        bit          wen, taken;
        string       tg;
        ins = m_im[m_pc[7:2]];
        op  = ins[31:26];
        fn  = ins[5:0];
        rs  = int'(ins[25:21]);
        rt  = int'(ins[20:16]);
        rd  = int'(ins[15:11]);
        a   = m_reg[rs];
        b   = m_reg[rt];
        imm = {{16{ins[15]}}, ins[15:0]};
        y   = '0;
        kind = 0;
        tg  = "R9";
        if (op == 6'b000000) begin
            kind = 1;
            tg   = "R3";
            case (fn)
                6'b100000: y = a + b;
                6'b100010: y = a - b;
                6'b100100: y = a & b;
                6'b100101: y = a | b;
                6'b101010: begin y = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0; tg = "R4"; end
                default: begin kind = 0; tg = "R9"; end
            endcase
        end else if (op == 6'b100011) begin
            kind = 2; y = a + imm; tg = (m_pc == 32'd84) ? "R10" : "R5";
        end else if (op == 6'b101011) begin
            kind = 3; y = a + imm; tg = (y[31:8] != 0) ? "R10" : "R6";
        end else if (op == 6'b000100) begin
            kind = 4; y = a - b; tg = "R7";
        end
        dst = (kind == 1) ? rd : rt;
        if ((kind == 1 || kind == 2) && (rs == 0 || dst == 0 || (kind == 1 && rt == 0))) tg = "R8";
        wen = (kind == 1) || (kind == 2);
        wbd = (kind == 2) ? m_dm[y[7:2]] : y;
        taken = (kind == 4) && (a == b);
        nxt = m_pc + 32'd4;
        if (taken) nxt = nxt + (imm << 2);

        chk(m_prev_br ? "R7" : "R2", "pc", pc_o, m_pc);
        chk(tg, "wb_en", {31'b0, wb_en_o}, {31'b0, wen});
        chk(kind == 3 ? "R6" : tg, "dm_we", {31'b0, dm_we_o}, {31'b0, kind == 3});
        if (wen) begin
            chk("R11", "wb_addr", {27'b0, wb_addr_o}, dst);
            chk(tg, "wb_data", wb_data_o, wbd);
        end
        if (kind == 3) begin
            chk(tg, "dm_addr", dm_addr_o, y);
            chk("R6", "dm_wdata", dm_wdata_o, b);
        end

        if (wen && dst != 0) m_reg[dst] = wbd;
        if (kind == 3) m_dm[y[7:2]] = b;
        m_pc = nxt;
        m_prev_br = taken;
    endtask

    task automatic run(int n);
        for (int c = 0; c < n; c++) begin
            #1;
            step_and_compare();
            @(negedge clk);
        end
    endtask

    initial begin
        logic [31:0] prog [MW];
        rst = 1'b1; ld_we = 1'b0; ld_dmem = 1'b0; ld_addr = '0; ld_data = '0;
        for (int i = 0; i < MW; i++) prog[i] = 32'hFC00_0000;
        prog[0]  = enc_i(6'b100011, 0, 1, 0);
        prog[1]  = enc_i(6'b100011, 0, 2, 4);
        prog[2]  = enc_i(6'b100011, 0, 3, 8);
        prog[3]  = enc_r(1, 3, 4, 6'b100000);
        prog[4]  = enc_r(1, 3, 5, 6'b100010);
        prog[5]  = enc_r(1, 3, 6, 6'b100100);
        prog[6]  = enc_r(1, 2, 7, 6'b100101);
        prog[7]  = enc_r(2, 1, 8, 6'b101010);
        prog[8]  = enc_r(1, 2, 9, 6'b101010);
        prog[9]  = enc_r(1, 1, 0, 6'b100000);
        prog[10] = enc_r(0, 1, 10, 6'b100000);
        prog[11] = enc_i(6'b101011, 0, 4, 16);
        prog[12] = enc_i(6'b100011, 0, 11, 16);
        prog[13] = enc_i(6'b000100, 4, 11, 2);
        prog[14] = enc_r(1, 1, 12, 6'b100000);
        prog[15] = enc_r(1, 1, 12, 6'b100000);
        prog[16] = enc_i(6'b000100, 1, 2, 5);
        prog[17] = 32'hFC00_0000;
        prog[18] = enc_r(1, 2, 3, 6'b000111);
        prog[19] = enc_i(6'b100011, 3, 13, -3);
        prog[20] = enc_i(6'b101011, 0, 2, 256);
        prog[21] = enc_i(6'b100011, 0, 14, 0);
        prog[22] = enc_i(6'b100011, 0, 15, 12);
        prog[23] = enc_r(15, 1, 16, 6'b101010);
        prog[24] = enc_i(6'b000100, 0, 0, -25);

        for (int i = 0; i < MW; i++) m_dm[i] = 32'(i * 3 + 1);
        m_dm[0] = 32'd5;
        m_dm[1] = 32'hFFFF_FFFD;
        m_dm[2] = 32'd7;
        m_dm[3] = 32'h8000_0000;
        m_dm[4] = 32'd99;

        repeat (2) @(negedge clk);
        for (int i = 0; i < MW; i++) begin
            ld_we = 1'b1; ld_dmem = 1'b0; ld_addr = 32'(i * 4); ld_data = prog[i];
            m_im[i] = prog[i];
            @(negedge clk);
        end
        for (int i = 0; i < MW; i++) begin
            ld_we = 1'b1; ld_dmem = 1'b1; ld_addr = 32'(i * 4); ld_data = m_dm[i];
            @(negedge clk);
        end
        ld_we = 1'b0;
        #1;
        chk("R1", "pc after reset", pc_o, 32'd0);
        model_reset();
        rst = 1'b0;
        run(150);

        // Mid-run reset: registers clear, data store survives.
        rst = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        chk("R1", "pc after second reset", pc_o, 32'd0);
        model_reset();
        rst = 1'b0;
        run(80);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not end, actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule